// File: doc/BRIEF.md
# Idle-Mode Clock Gating Controller

This block decides, cycle by cycle, which clock domains of a processor subsystem may run. It produces one registered clock-enable per domain, plus an enable for the processor clock itself, and leaves the gating cells to the clock tree. Software sets it up through three small write-only registers. The first holds per-domain "stop when idle" choices, the wake-up policy and a PLL-idle permission. The second holds one static enable per domain and a DMA clock policy. The third holds a restart delay.

The processor enters idle when a hardware idle request arrives or when software writes the idle-go bit. It leaves idle on an interrupt. Depending on the wake-up policy bit, the interrupt is either enough on its own or must coincide with the active-low wake pin, which is synchronised inside the block. While idle, the block may also ask the PLLs to sleep, provided the whole subsystem is quiet.

A power-restore input forces every domain off while low. After it rises, the clocks are held off for a programmed number of extra cycles. A watchdog-mode input keeps the watchdog clock running whatever the registers, idle state or power-restore say.

Top module: `idle_clkgate_ctrl`

## Requirements
- R1: After reset, every bit of `ck_en_o` and `cpu_ck_en_o` is 1, `idle_o` and `pll_idle_o` are 0, all static enables are 1, and every other register bit, including the restart delay, is 0.
- R2: Writes with `wr_sel`=1 load the static enables from `wr_data[6:0]`. The bit order is watchdog 0, reference/OS-timer 1, peripheral 2, timer 3, peripheral bus 4, DMA 5, traffic controller 6, and `ck_en_o` uses the same order. A static enable of 0 drives its domain's enable to 0 from the second rising edge after the write. A write with `wr_sel`=3 changes nothing.
- R3: `idle_o` rises at the rising edge that samples `idle_req_i` high, or that samples a `wr_sel`=0 write with `wr_data[11]`=1. `cpu_ck_en_o` falls at that same edge and stays 0 while `idle_o` is 1.
- R4: In the idle register (`wr_sel`=0), bits 0, 1, 2 and 9 are the stop-on-idle bits of the watchdog, reference, peripheral and timer domains. While idle, a domain whose bit is 1 has its enable at 0. A domain whose bit is 0 keeps running.
- R5: Idle-register bit 6 stops the peripheral-bus domain and the DMA domain while idle. It stops the traffic-controller domain only while `dsp_idle_i` is also 1.
- R6: With idle-register bit 10 at 0, idle ends only when `irq_i` is 1 and `wake_n_i` is 0. `wake_n_i` passes through SYNC_STAGES flops (2 by default), so `idle_o` falls at the third edge after `wake_n_i` goes low while `irq_i` is held high.
- R7: With idle-register bit 10 at 1, `irq_i` alone ends idle at the edge that samples it. `irq_i` while not idle leaves `idle_o` at 0.
- R8: With static-enable-register bit 8 at 1, the DMA enable is 1 only on the edge after a cycle in which `dma_req_i` is 1.
- R9: While `wdog_mode_i` is 1, the watchdog enable (bit 0) is 1 at the following edge, regardless of its static enable, its stop bit, idle state or power-restore.
- R10: With idle-register bit 7 at 1, `pll_idle_o` is 1 exactly while the block is idle, `dsp_idle_i` is 1, `dma_req_i` and `posted_wr_i` are 0, and the peripheral and peripheral-bus enables are 0. With bit 7 at 0 it stays 0.
- R11: Write `wr_sel`=2 with `wr_data[4:0]` = D to set the restart delay. While `pwr_ok_i` is 0, every enable except a watchdog-mode watchdog is 0. Let E0 be the first edge that samples `pwr_ok_i` at 1. The enables return at edge E0 + D + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 idle, 1 static enable, 2 restart delay |
| wr_data | input | CFG_W | Write data |
| idle_req_i | input | 1 | Hardware idle request (wait for interrupt) |
| irq_i | input | 1 | Interrupt pending |
| wake_n_i | input | 1 | Active-low external wake pin, asynchronous |
| dsp_idle_i | input | 1 | DSP is in global idle |
| dma_req_i | input | 1 | DMA request or transfer active |
| posted_wr_i | input | 1 | A posted peripheral write is queued |
| wdog_mode_i | input | 1 | Internal timer works as a watchdog |
| pwr_ok_i | input | 1 | Power restored |
| ck_en_o | output | NDOM | Per-domain clock enables, registered |
| cpu_ck_en_o | output | 1 | Processor clock enable, registered |
| idle_o | output | 1 | Processor is in idle mode |
| pll_idle_o | output | 1 | Request for the PLLs to enter idle |

## Verification
Idle entry is driven with different stop-bit sets: single domains, the interface group with and without DSP idle, and the watchdog. This separates the per-domain stop path from the group path and from the traffic-controller special case. Exit is tried with the pin high and then low under the strict wake policy, and with the interrupt alone under the relaxed policy. The pin-low case is counted edge by edge to expose the synchroniser depth. The PLL-idle request is toggled by each blocking condition in turn. The restart delay is stepped with D=3 and D=0, which pins down the off-by-one at the power-restore edge.

// File: rtl/icg_pkg.sv
package icg_pkg;
   localparam int NDOM = 7;

   // domain indices: shared by static enables and ck_en_o
   localparam int DOM_WDG = 0;
   localparam int DOM_REF = 1;
   localparam int DOM_PER = 2;
   localparam int DOM_TMR = 3;
   localparam int DOM_BUS = 4;
   localparam int DOM_DMA = 5;
   localparam int DOM_TCC = 6;

   // idle register bit positions
   localparam int IB_STOP_WDG = 0;
   localparam int IB_STOP_REF = 1;
   localparam int IB_STOP_PER = 2;
   localparam int IB_STOP_IFC = 6;
   localparam int IB_PLL_EN   = 7;
   localparam int IB_STOP_TMR = 9;
   localparam int IB_WAKE_ANY = 10;
   localparam int IB_IDLE_GO  = 11;

   // static enable register bit positions beyond the domain bits
   localparam int EB_DMA_ONREQ = 8;

   localparam int MIN_CFG_W = IB_IDLE_GO + 1;

   localparam logic [1:0] SEL_IDLE = 2'd0;
   localparam logic [1:0] SEL_EN   = 2'd1;
   localparam logic [1:0] SEL_DLY  = 2'd2;

   typedef struct packed {
      logic            wake_any;
      logic            pll_en;
      logic            dma_onreq;
      logic [NDOM-1:0] stop;
      logic [NDOM-1:0] static_en;
   } cfg_t;
endpackage

// File: rtl/icg_regs.sv
module icg_regs
   import icg_pkg::*;
#(
   parameter int CFG_W = 16,
   parameter int DLY_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CFG_W-1:0] wr_data,
   output cfg_t             cfg,
   output logic [DLY_W-1:0] dly,
   output logic             idle_go
);
   logic            stop_wdg_q, stop_ref_q, stop_per_q, stop_tmr_q, stop_ifc_q;
   logic            pll_en_q, wake_any_q, dma_onreq_q;
   logic [NDOM-1:0] en_q;
   logic [DLY_W-1:0] dly_q;

   logic wr_idle, wr_en_reg, wr_dly;
   assign wr_idle   = wr_en && (wr_sel == SEL_IDLE);
   assign wr_en_reg = wr_en && (wr_sel == SEL_EN);
   assign wr_dly    = wr_en && (wr_sel == SEL_DLY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_wdg_q  <= 1'b0;
         stop_ref_q  <= 1'b0;
         stop_per_q  <= 1'b0;
         stop_tmr_q  <= 1'b0;
         stop_ifc_q  <= 1'b0;
         pll_en_q    <= 1'b0;
         wake_any_q  <= 1'b0;
      end else if (wr_idle) begin
         stop_wdg_q  <= wr_data[IB_STOP_WDG];
         stop_ref_q  <= wr_data[IB_STOP_REF];
         stop_per_q  <= wr_data[IB_STOP_PER];
         stop_tmr_q  <= wr_data[IB_STOP_TMR];
         stop_ifc_q  <= wr_data[IB_STOP_IFC];
         pll_en_q    <= wr_data[IB_PLL_EN];
         wake_any_q  <= wr_data[IB_WAKE_ANY];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q        <= '1;
         dma_onreq_q <= 1'b0;
      end else if (wr_en_reg) begin
         en_q        <= wr_data[NDOM-1:0];
         dma_onreq_q <= wr_data[EB_DMA_ONREQ];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dly_q <= '0;
      else if (wr_dly) dly_q <= wr_data[DLY_W-1:0];
   end

   // idle-go is a write-one pulse, not a stored bit
   assign idle_go = wr_idle && wr_data[IB_IDLE_GO];

   always_comb begin
      cfg           = '0;
      cfg.static_en = en_q;
      cfg.dma_onreq = dma_onreq_q;
      cfg.pll_en    = pll_en_q;
      cfg.wake_any  = wake_any_q;
      cfg.stop[DOM_WDG] = stop_wdg_q;
      cfg.stop[DOM_REF] = stop_ref_q;
      cfg.stop[DOM_PER] = stop_per_q;
      cfg.stop[DOM_TMR] = stop_tmr_q;
      cfg.stop[DOM_BUS] = stop_ifc_q;
      cfg.stop[DOM_DMA] = stop_ifc_q;
      cfg.stop[DOM_TCC] = stop_ifc_q;
   end

   assign dly = dly_q;
endmodule

// File: rtl/icg_idle_ctl.sv
module icg_idle_ctl #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic idle_req,
   input  logic idle_go,
   input  logic irq,
   input  logic wake_n,
   input  logic wake_any,
   output logic idle_nxt,
   output logic idle_q
);
   logic pin_low;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign pin_low = ~wake_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '1;
            end else begin
               sh_q[0] <= wake_n;
               for (int i = 1; i < SYNC_STAGES; i++) sh_q[i] <= sh_q[i-1];
            end
         end
         assign pin_low = ~sh_q[SYNC_STAGES-1];
      end
   endgenerate

   logic wake;
   assign wake = irq && (wake_any || pin_low);

   always_comb begin
      if (idle_q) idle_nxt = ~wake;
      else        idle_nxt = idle_req | idle_go;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idle_q <= 1'b0;
      else        idle_q <= idle_nxt;
   end
endmodule

// File: rtl/icg_restart.sv
module icg_restart #(
   parameter int DLY_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_ok,
   input  logic [DLY_W-1:0] dly,
   output logic             hold
);
   logic             pwr_q;
   logic [DLY_W-1:0] cnt_q;
   logic             rise;

   assign rise = pwr_ok & ~pwr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_q <= 1'b1;
         cnt_q <= '0;
      end else begin
         pwr_q <= pwr_ok;
         if (rise)              cnt_q <= dly;
         else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      end
   end

   assign hold = ~pwr_ok | rise | (cnt_q != '0);
endmodule

// File: rtl/icg_en_gen.sv
module icg_en_gen
   import icg_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            idle_nxt,
   input  logic            hold,
   input  cfg_t            cfg,
   input  logic            dsp_idle,
   input  logic            dma_req,
   input  logic            posted_wr,
   input  logic            wdog_mode,
   output logic [NDOM-1:0] ck_en,
   output logic            cpu_en,
   output logic            pll_idle
);
   logic [NDOM-1:0] run_c;

   generate
      for (genvar d = 0; d < NDOM; d++) begin : g_dom
         logic stop_c;
         if (d == DOM_TCC) begin : g_tc
            assign stop_c = idle_nxt & cfg.stop[d] & dsp_idle;
         end else begin : g_plain
            assign stop_c = idle_nxt & cfg.stop[d];
         end

         if (d == DOM_DMA) begin : g_dma
            assign run_c[d] = cfg.static_en[d] & ~hold &
                              (cfg.dma_onreq ? dma_req : ~stop_c);
         end else if (d == DOM_WDG) begin : g_wdg
            assign run_c[d] = (cfg.static_en[d] & ~hold & ~stop_c) | wdog_mode;
         end else begin : g_gen
            assign run_c[d] = cfg.static_en[d] & ~hold & ~stop_c;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ck_en[d] <= 1'b1;
            else        ck_en[d] <= run_c[d];
         end
      end
   endgenerate

   logic pll_c;
   assign pll_c = cfg.pll_en & idle_nxt & dsp_idle & ~dma_req & ~posted_wr &
                  ~run_c[DOM_PER] & ~run_c[DOM_BUS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_en   <= 1'b1;
         pll_idle <= 1'b0;
      end else begin
         cpu_en   <= ~idle_nxt & ~hold;
         pll_idle <= pll_c;
      end
   end
endmodule

// File: rtl/idle_clkgate_ctrl.sv
module idle_clkgate_ctrl
   import icg_pkg::*;
#(
   parameter int CFG_W       = 16,
   parameter int DLY_W       = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CFG_W-1:0] wr_data,
   input  logic             idle_req_i,
   input  logic             irq_i,
   input  logic             wake_n_i,
   input  logic             dsp_idle_i,
   input  logic             dma_req_i,
   input  logic             posted_wr_i,
   input  logic             wdog_mode_i,
   input  logic             pwr_ok_i,
   output logic [NDOM-1:0]  ck_en_o,
   output logic             cpu_ck_en_o,
   output logic             idle_o,
   output logic             pll_idle_o
);
   generate
      if (CFG_W < MIN_CFG_W) begin : g_bad_cfg_w
         $error("CFG_W too narrow for the idle register");
      end
      if (DLY_W < 1 || DLY_W > CFG_W) begin : g_bad_dly_w
         $error("DLY_W must lie in 1..CFG_W");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   cfg_t             cfg_q;
   logic [DLY_W-1:0] dly;
   logic             idle_go;
   logic             idle_nxt;
   logic             hold;

   icg_regs #(.CFG_W(CFG_W), .DLY_W(DLY_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .cfg     (cfg_q),
      .dly     (dly),
      .idle_go (idle_go)
   );

   icg_idle_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_idle (
      .clk      (clk),
      .rst_n    (rst_n),
      .idle_req (idle_req_i),
      .idle_go  (idle_go),
      .irq      (irq_i),
      .wake_n   (wake_n_i),
      .wake_any (cfg_q.wake_any),
      .idle_nxt (idle_nxt),
      .idle_q   (idle_o)
   );

   icg_restart #(.DLY_W(DLY_W)) u_rst (
      .clk    (clk),
      .rst_n  (rst_n),
      .pwr_ok (pwr_ok_i),
      .dly    (dly),
      .hold   (hold)
   );

   icg_en_gen u_en (
      .clk       (clk),
      .rst_n     (rst_n),
      .idle_nxt  (idle_nxt),
      .hold      (hold),
      .cfg       (cfg_q),
      .dsp_idle  (dsp_idle_i),
      .dma_req   (dma_req_i),
      .posted_wr (posted_wr_i),
      .wdog_mode (wdog_mode_i),
      .ck_en     (ck_en_o),
      .cpu_en    (cpu_ck_en_o),
      .pll_idle  (pll_idle_o)
   );
endmodule

// File: rtl/icg_chk.sv
module icg_chk
   import icg_pkg::*;
(
   input logic            clk,
   input logic            rst_n,
   input logic            idle_req_i,
   input logic            idle_go,
   input logic            dma_req_i,
   input logic            wdog_mode_i,
   input logic            pwr_ok_i,
   input logic [NDOM-1:0] static_en,
   input logic            dma_onreq,
   input logic [NDOM-1:0] ck_en_o,
   input logic            cpu_ck_en_o,
   input logic            idle_o,
   input logic            pll_idle_o
);
   // R9
   wdog_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_mode_i |=> ck_en_o[DOM_WDG]);

   // R11
   pwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_ok_i |=> (ck_en_o[NDOM-1:1] == '0) && !cpu_ck_en_o);

   // R3
   cpu_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle_o |-> !cpu_ck_en_o);

   // R3
   idle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle_o && !idle_req_i && !idle_go) |=> !idle_o);

   // R10
   pll_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pll_idle_o |-> idle_o && !ck_en_o[DOM_PER] && !ck_en_o[DOM_BUS]);

   // R8
   dma_onreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_onreq && !dma_req_i) |=> !ck_en_o[DOM_DMA]);

   generate
      for (genvar d = 1; d < NDOM; d++) begin : g_st
         // R2
         static_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !static_en[d] |=> !ck_en_o[d]);
      end
   endgenerate
endmodule

bind idle_clkgate_ctrl icg_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .idle_req_i  (idle_req_i),
   .idle_go     (idle_go),
   .dma_req_i   (dma_req_i),
   .wdog_mode_i (wdog_mode_i),
   .pwr_ok_i    (pwr_ok_i),
   .static_en   (cfg_q.static_en),
   .dma_onreq   (cfg_q.dma_onreq),
   .ck_en_o     (ck_en_o),
   .cpu_ck_en_o (cpu_ck_en_o),
   .idle_o      (idle_o),
   .pll_idle_o  (pll_idle_o)
);

// File: tb/idle_clkgate_ctrl_test.sv
`timescale 1ns/1ps
module idle_clkgate_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [15:0] wr_data = '0;
   logic        idle_req_i = 1'b0, irq_i = 1'b0, wake_n_i = 1'b1;
   logic        dsp_idle_i = 1'b0, dma_req_i = 1'b0, posted_wr_i = 1'b0;
   logic        wdog_mode_i = 1'b0, pwr_ok_i = 1'b1;
   logic [6:0]  ck_en_o;
   logic        cpu_ck_en_o, idle_o, pll_idle_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   idle_clkgate_ctrl uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .idle_req_i(idle_req_i), .irq_i(irq_i), .wake_n_i(wake_n_i),
      .dsp_idle_i(dsp_idle_i), .dma_req_i(dma_req_i), .posted_wr_i(posted_wr_i),
      .wdog_mode_i(wdog_mode_i), .pwr_ok_i(pwr_ok_i),
      .ck_en_o(ck_en_o), .cpu_ck_en_o(cpu_ck_en_o), .idle_o(idle_o),
      .pll_idle_o(pll_idle_o)
   );

   task automatic step(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] sel, logic [15:0] data);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      step();
      wr_en = 1'b0;
   endtask

   task automatic enter_idle();
      idle_req_i = 1'b1;
      step();
      idle_req_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "ck_en", ck_en_o, 'h7F);
      chk("R1", "cpu_en", cpu_ck_en_o, 1);
      chk("R1", "idle", idle_o, 0);
      chk("R1", "pll_idle", pll_idle_o, 0);
   endtask

   task automatic t_static();
      wr(2'd1, 16'h0073);
      step();
      chk("R2", "ck_en static off", ck_en_o, 'h73);
      wr(2'd1, 16'h007F);
      step();
      wr(2'd3, 16'h0000);
      step();
      chk("R2", "sel3 ignored", ck_en_o, 'h7F);
   endtask

   task automatic t_stop_wake0();
      wr(2'd0, 16'h0006);
      enter_idle();
      chk("R3", "idle set", idle_o, 1);
      chk("R3", "cpu off", cpu_ck_en_o, 0);
      chk("R4", "ck_en idle", ck_en_o, 'h79);
      irq_i = 1'b1;
      step(3);
      chk("R6", "pin high keeps idle", idle_o, 1);
      wake_n_i = 1'b0;
      step(2);
      chk("R6", "sync delay", idle_o, 1);
      step();
      chk("R6", "idle cleared", idle_o, 0);
      chk("R6", "ck_en restored", ck_en_o, 'h7F);
      irq_i = 1'b0; wake_n_i = 1'b1;
      step(3);
   endtask

   task automatic t_wake1();
      irq_i = 1'b1;
      step();
      chk("R7", "irq when awake", idle_o, 0);
      irq_i = 1'b0;
      wr(2'd0, 16'h0400);
      enter_idle();
      chk("R7", "idle set", idle_o, 1);
      irq_i = 1'b1;
      step();
      chk("R7", "irq alone wakes", idle_o, 0);
      irq_i = 1'b0;
      step();
   endtask

   task automatic t_ifc();
      wr(2'd0, 16'h0440);
      enter_idle();
      chk("R5", "bus+dma stopped, tc runs", ck_en_o, 'h4F);
      dsp_idle_i = 1'b1;
      step();
      chk("R5", "tc stops with dsp idle", ck_en_o, 'h0F);
      chk("R10", "pll disabled", pll_idle_o, 0);
      irq_i = 1'b1;
      step();
      chk("R5", "exit restores", ck_en_o, 'h7F);
      irq_i = 1'b0; dsp_idle_i = 1'b0;
      step();
   endtask

   task automatic t_dma();
      wr(2'd1, 16'h017F);
      step();
      chk("R8", "dma off by default", ck_en_o, 'h5F);
      dma_req_i = 1'b1;
      step();
      chk("R8", "dma on request", ck_en_o, 'h7F);
      dma_req_i = 1'b0;
      step();
      chk("R8", "dma off again", ck_en_o, 'h5F);
      wr(2'd1, 16'h007F);
      step();
   endtask

   task automatic t_pll();
      wr(2'd0, 16'h04C4);
      dsp_idle_i = 1'b1;
      enter_idle();
      chk("R10", "pll idle asserted", pll_idle_o, 1);
      chk("R10", "ck_en during pll idle", ck_en_o, 'h0B);
      posted_wr_i = 1'b1;
      step();
      chk("R10", "posted write blocks", pll_idle_o, 0);
      posted_wr_i = 1'b0; dma_req_i = 1'b1;
      step();
      chk("R10", "dma blocks", pll_idle_o, 0);
      dma_req_i = 1'b0;
      step();
      chk("R10", "pll idle again", pll_idle_o, 1);
      dsp_idle_i = 1'b0;
      step();
      chk("R10", "dsp active blocks", pll_idle_o, 0);
      irq_i = 1'b1;
      step();
      chk("R10", "wake drops pll", pll_idle_o, 0);
      irq_i = 1'b0;
      step();
   endtask

   task automatic t_wdog();
      wr(2'd1, 16'h007E);
      step();
      chk("R9", "wdg static off", ck_en_o, 'h7E);
      wdog_mode_i = 1'b1;
      step();
      chk("R9", "wdg forced on", ck_en_o, 'h7F);
      wr(2'd0, 16'h0401);
      enter_idle();
      chk("R9", "wdg on in idle", ck_en_o, 'h7F);
      irq_i = 1'b1;
      step();
      irq_i = 1'b0;
      pwr_ok_i = 1'b0;
      step();
      chk("R9", "wdg on without power", ck_en_o, 'h01);
      pwr_ok_i = 1'b1;
      wdog_mode_i = 1'b0;
      step(3);
      chk("R9", "wdg off after mode", ck_en_o, 'h7E);
      wr(2'd1, 16'h007F);
      step();
   endtask

   task automatic t_restart();
      wr(2'd2, 16'h0003);
      pwr_ok_i = 1'b0;
      step();
      chk("R11", "power low ck_en", ck_en_o, 0);
      chk("R11", "power low cpu", cpu_ck_en_o, 0);
      pwr_ok_i = 1'b1;
      step(4);
      chk("R11", "held for D+1 edges", ck_en_o, 0);
      step();
      chk("R11", "restart after delay", ck_en_o, 'h7F);
      chk("R11", "cpu restart", cpu_ck_en_o, 1);
      wr(2'd2, 16'h0000);
      pwr_ok_i = 1'b0;
      step();
      pwr_ok_i = 1'b1;
      step();
      chk("R11", "D=0 first edge held", ck_en_o, 0);
      step();
      chk("R11", "D=0 restart", ck_en_o, 'h7F);
   endtask

   task automatic t_go_bit();
      wr(2'd0, 16'h0C00);
      chk("R3", "idle-go bit", idle_o, 1);
      chk("R3", "idle-go cpu off", cpu_ck_en_o, 0);
      irq_i = 1'b1;
      step();
      chk("R7", "exit after go", idle_o, 0);
      irq_i = 1'b0;
      step();
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step();
      t_reset();
      t_static();
      t_stop_wake0();
      t_wake1();
      t_ifc();
      t_dma();
      t_pll();
      t_wdog();
      t_restart();
      t_go_bit();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog run did not finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule